// File: doc/BRIEF.md
# Power-On Reset Release Sequencer

This block holds a chip in reset from power-up and lets its processor start only after a fixed series of waits. Its only inputs are a free-running reference clock and a flag from an analog supply comparator. The flag is high while the supply sits above the release threshold (about 1.59 V). When the flag rises, the block leaves reset, releases the internal reset line and turns on the internal high-speed oscillator by itself. It then times a supply and regulator settling interval, long enough for the oscillator to reach its frequency accuracy. After that it times a reset-processing interval and finally raises the CPU-run strobe.

The sequence has four states: RESET (code 0), STABILIZE (code 1), PROCESS (code 2) and RUN (code 3). The transitions are:
- RESET to STABILIZE once the synchronized flag is high.
- STABILIZE to PROCESS when the settling interval ends.
- PROCESS to RUN when the processing interval ends.
- RUN holds.

A low flag sends every state straight back to RESET, without waiting for a clock edge. Both interval counters restart from zero on the next rise. The interval lengths are parameters counted in reference-clock cycles, so that a short configuration can be used for test.

Top module: `por_release_seq`

## Requirements
- R1: While `supply_ok` is low, the outputs are `rst_int_n`=0, `hosc_en`=0, `cpu_run`=0 and `phase`=0 (RESET). This holds without any clock edge.
- R2: `supply_ok` passes through `SYNC_STAGES` flops. After a rise, the block stays in RESET for the first `SYNC_STAGES` clock edges and leaves it on edge `SYNC_STAGES`+1.
- R3: On leaving RESET, `rst_int_n` and `hosc_en` both go to 1 in the same cycle, and they stay at 1 in every later phase.
- R4: STABILIZE (`phase`=1) lasts exactly `STAB_CYCLES` clock cycles and is followed by PROCESS.
- R5: PROCESS (`phase`=2) lasts exactly `PROC_CYCLES` cycles and is followed by RUN (`phase`=3). `cpu_run` is 1 only in RUN.
- R6: RUN is held for as long as `supply_ok` stays high.
- R7: A fall of `supply_ok` in any phase returns the block to RESET at once. The next rise repeats the full timing from zero.
- R8: The `phase` codes are RESET=0, STABILIZE=1, PROCESS=2 and RUN=3. The states only advance in that order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Free-running reference clock |
| supply_ok | input | 1 | Asynchronous comparator flag, high when the supply is above the release threshold |
| rst_int_n | output | 1 | Internal reset, active low |
| hosc_en | output | 1 | Internal high-speed oscillator enable |
| cpu_run | output | 1 | CPU may run |
| phase | output | 2 | Current sequence state code |

## Verification
The checker watches every cycle while the flag is high. It checks that the states only move forward in the allowed order and that RUN is sticky. It counts the cycles spent in STABILIZE and PROCESS and checks that each phase exits on exactly its configured cycle. It also checks that the CPU strobe only rises out of PROCESS.

Some behaviours happen while the checker is disabled, and only the bench scenarios can show them. These are the immediate, clockless return to reset when the flag falls, the synchronizer delay on release, and the full restart of both intervals. The bench sweeps the flag drop across every cycle of the sequence.

// File: rtl/por_seq_pkg.sv
package por_seq_pkg;

    typedef enum logic [1:0] {
        PH_RESET     = 2'd0,
        PH_STABILIZE = 2'd1,
        PH_PROCESS   = 2'd2,
        PH_RUN       = 2'd3
    } phase_e;

    localparam int NUM_TIMED = 2;

endpackage

// File: rtl/por_detect_sync.sv
module por_detect_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic async_ok,
    output logic sync_ok
);
    logic [STAGES-1:0] chain_q;

    // low flag clears the chain at once; release ripples in
    always_ff @(posedge clk or negedge async_ok) begin
        if (!async_ok) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], 1'b1};
        end
    end

    assign sync_ok = chain_q[STAGES-1];
endmodule

// File: rtl/por_phase_timer.sv
module por_phase_timer #(
    parameter int LIMIT = 16,
    localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
    input  logic clk,
    input  logic arst_n,
    input  logic run,
    output logic done
);
    logic [W-1:0] cnt_q;

    assign done = run && (cnt_q == W'(LIMIT - 1));

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (!done) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/por_release_seq.sv
module por_release_seq
    import por_seq_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int STAB_CYCLES = 8000,
    parameter int PROC_CYCLES = 64
) (
    input  logic       clk_ref,
    input  logic       supply_ok,
    output logic       rst_int_n,
    output logic       hosc_en,
    output logic       cpu_run,
    output logic [1:0] phase
);
    localparam int LIMITS [NUM_TIMED] = '{STAB_CYCLES, PROC_CYCLES};
    localparam phase_e TIMED_PH [NUM_TIMED] = '{PH_STABILIZE, PH_PROCESS};

    phase_e state_q, state_d;
    logic   sync_ok;
    logic [NUM_TIMED-1:0] timer_done;

    por_detect_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk      (clk_ref),
        .async_ok (supply_ok),
        .sync_ok  (sync_ok)
    );

    for (genvar g = 0; g < NUM_TIMED; g++) begin : g_timer
        por_phase_timer #(.LIMIT(LIMITS[g])) timer_i (
            .clk    (clk_ref),
            .arst_n (supply_ok),
            .run    (state_q == TIMED_PH[g]),
            .done   (timer_done[g])
        );
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_RESET:     if (sync_ok)       state_d = PH_STABILIZE;
            PH_STABILIZE: if (timer_done[0]) state_d = PH_PROCESS;
            PH_PROCESS:   if (timer_done[1]) state_d = PH_RUN;
            PH_RUN:                          state_d = PH_RUN;
            default:                         state_d = PH_RESET;
        endcase
    end

    always_ff @(posedge clk_ref or negedge supply_ok) begin
        if (!supply_ok) begin
            state_q <= PH_RESET;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        rst_int_n = 1'b1;
        hosc_en   = 1'b1;
        cpu_run   = 1'b0;
        unique case (state_q)
            PH_RESET: begin
                rst_int_n = 1'b0;
                hosc_en   = 1'b0;
            end
            PH_STABILIZE, PH_PROCESS: ;
            PH_RUN:   cpu_run = 1'b1;
            default: begin
                rst_int_n = 1'b0;
                hosc_en   = 1'b0;
            end
        endcase
    end

    assign phase = state_q;
endmodule

// File: rtl/por_release_seq_chk.sv
module por_release_seq_chk #(
    parameter int STAB_CYCLES = 8000,
    parameter int PROC_CYCLES = 64
) (
    input logic       clk_ref,
    input logic       supply_ok,
    input logic       rst_int_n,
    input logic       hosc_en,
    input logic       cpu_run,
    input logic [1:0] phase
);
    logic [31:0] dwell_q;
    logic [1:0]  prev_q;

    always_ff @(posedge clk_ref or negedge supply_ok) begin
        if (!supply_ok) begin
            dwell_q <= '0;
            prev_q  <= 2'd0;
        end else begin
            prev_q  <= phase;
            dwell_q <= (phase == prev_q) ? dwell_q + 1 : 32'd1;
        end
    end

    // R8
    reset_exit_chk: assert property (@(posedge clk_ref) disable iff (!supply_ok)
        (phase == 2'd0) |=> (phase == 2'd0 || phase == 2'd1));
    // R6
    run_sticky_chk: assert property (@(posedge clk_ref) disable iff (!supply_ok)
        (phase == 2'd3) |=> (phase == 2'd3));
    // R4
    stab_hold_chk: assert property (@(posedge clk_ref) disable iff (!supply_ok)
        (phase == 2'd1 && prev_q == 2'd1 && dwell_q + 1 < STAB_CYCLES) |=> (phase == 2'd1));
    // R4
    stab_exit_chk: assert property (@(posedge clk_ref) disable iff (!supply_ok)
        (phase == 2'd1 && prev_q == 2'd1 && dwell_q + 1 == STAB_CYCLES) |=> (phase == 2'd2));
    // R5
    proc_exit_chk: assert property (@(posedge clk_ref) disable iff (!supply_ok)
        (phase == 2'd2 && prev_q == 2'd2 && dwell_q + 1 == PROC_CYCLES) |=> (phase == 2'd3));
    // R5
    run_entry_chk: assert property (@(posedge clk_ref) disable iff (!supply_ok)
        $rose(cpu_run) |-> ($past(phase) == 2'd2));
    // R3
    release_pair_chk: assert property (@(posedge clk_ref) disable iff (!supply_ok)
        $rose(rst_int_n) |-> (hosc_en && $past(phase) == 2'd0));
endmodule

bind por_release_seq por_release_seq_chk #(
    .STAB_CYCLES (STAB_CYCLES),
    .PROC_CYCLES (PROC_CYCLES)
) chk_i (
    .clk_ref   (clk_ref),
    .supply_ok (supply_ok),
    .rst_int_n (rst_int_n),
    .hosc_en   (hosc_en),
    .cpu_run   (cpu_run),
    .phase     (phase)
);

// File: tb/por_release_seq_tb.sv
module por_release_seq_tb_top;
    localparam int SYNC  = 2;
    localparam int STAB  = 6;
    localparam int PROC  = 3;
    localparam int TOTAL = SYNC + STAB + PROC;

    logic       clk_ref = 1'b0;
    logic       supply_ok = 1'b0;
    logic       rst_int_n, hosc_en, cpu_run;
    logic [1:0] phase;

    int n_run  = 0;
    int n_fail = 0;

    por_release_seq #(
        .SYNC_STAGES (SYNC),
        .STAB_CYCLES (STAB),
        .PROC_CYCLES (PROC)
    ) dut_i (
        .clk_ref   (clk_ref),
        .supply_ok (supply_ok),
        .rst_int_n (rst_int_n),
        .hosc_en   (hosc_en),
        .cpu_run   (cpu_run),
        .phase     (phase)
    );

    always #2 clk_ref = ~clk_ref;

    function automatic logic [1:0] exp_phase(int n);
        if (n <= SYNC)             return 2'd0;
        if (n <= SYNC + STAB)      return 2'd1;
        if (n <= TOTAL)            return 2'd2;
        return 2'd3;
    endfunction

    task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_reset(string tag);
        check(tag, {rst_int_n, hosc_en, cpu_run, 1'b0}, 4'b0000);
        check(tag, {2'b00, phase}, 4'd0);
    endtask

    task automatic check_step(int n);
        logic [1:0] e = exp_phase(n);
        check("R2/R4/R5/R8 phase", {2'b00, phase}, {2'b00, e});
        check("R3 release", {2'b00, rst_int_n, hosc_en}, (e != 2'd0) ? 4'b0011 : 4'b0000);
        check("R5 cpu_run", {3'b000, cpu_run}, {3'b000, e == 2'd3});
    endtask

    initial begin
        #1;
        check_reset("R1 power-up");
        repeat (3) @(negedge clk_ref);
        check_reset("R1 low flag held");
        // sweep the drop point across every cycle of the sequence (R7)
        for (int k = 0; k <= TOTAL + 2; k++) begin
            @(negedge clk_ref);
            supply_ok = 1'b1;
            for (int n = 1; n <= k; n++) begin
                @(negedge clk_ref);
                check_step(n);
            end
            #1 supply_ok = 1'b0;
            #0.5;
            check_reset("R7 immediate return");
            @(negedge clk_ref);
            check_reset("R1 after drop");
        end
        // full uninterrupted run, then long hold in RUN (R6)
        @(negedge clk_ref);
        supply_ok = 1'b1;
        for (int n = 1; n <= TOTAL + 20; n++) begin
            @(negedge clk_ref);
            check_step(n);
        end
        check("R6 run held", {2'b00, phase}, 4'd3);
        supply_ok = 1'b0;
        #0.5;
        check_reset("R7 drop from RUN");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 4);
        n_fail++;
        n_run++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule